// File: doc/BRIEF.md
# Five-Port Uop Issue Controller

This block sits between a pool of ready micro-operations and five execution ports. Each cycle up to three uops are offered in age order: slot 0 is the oldest. Each one carries an operation-class code. In the same cycle the block decides which uops issue and which port each one uses. It also reports the cycle in which each issued uop's result will be complete. Uops that are not granted stay with the producer, which offers them again on a later cycle. The block itself stores no uops.

The block keeps the timing rules of the functional units behind port 0 and port 1:
- Integer and float multiplies share one multiplier. A float multiply blocks that multiplier for the following cycle.
- The divider is not pipelined. Its occupancy is set cycle by cycle through a latency input.
- The branch unit cannot take branches on back-to-back cycles.

A free-running cycle counter is the time base for the completion stamps.

Top module: `disp_issue_ctrl`

## Requirements
- R1: A slot is granted only when its valid bit is set and its class code is one of 0 ALU, 1 IMUL, 2 FMUL, 3 DIV, 4 FADD, 5 LOAD, 6 STA (store address), 7 STD (store data), 8 BR. Codes 9 to 15 are never granted.
- R2: A granted uop reports its port as a 3-bit code. LOAD uses port 2, STA port 3, STD port 4, BR port 1, and IMUL, FMUL, DIV and FADD use port 0.
- R3: Each port accepts at most one uop per cycle. When two uops compete for a port, the lower-numbered (older) slot wins.
- R4: An ALU uop takes port 0 when no older slot has claimed it this cycle. Otherwise it takes port 1 if that port is unclaimed. If neither is free, the ALU uop is not granted.
- R5: The completion stamp is the current cycle count plus the latency, modulo 2^CYC_W. Latency is 1 for ALU, LOAD, STA, STD and BR; 3 for FADD; 4 for IMUL; 5 for FMUL; and the effective divide latency for DIV.
- R6: In the cycle after an FMUL grant, neither IMUL nor FMUL is granted. An IMUL grant does not block an IMUL in the next cycle.
- R7: The effective divide latency is the div_lat_i value clamped to the range 1 to DIV_MAX: 0 counts as 1, and values above DIV_MAX count as DIV_MAX. A divide granted at cycle t with effective latency L blocks every later divide until cycle t+L.
- R8: A BR uop is not granted in the cycle directly after a BR grant.
- R9: After reset the cycle count is 0 and no unit is blocked.
- R10: A uop that is blocked claims no port. Younger slots may then issue past it, including onto the port it would have used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uop_valid_i | input | NSLOT | Offer bit per slot; slot 0 is oldest |
| uop_cls_i | input | 4*NSLOT | Class code per slot |
| div_lat_i | input | DIV_W | Requested divide latency |
| grant_o | output | NSLOT | Slot issued this cycle |
| port_o | output | 3*NSLOT | Port code per slot |
| done_o | output | CYC_W*NSLOT | Completion cycle per slot |
| cycle_o | output | CYC_W | Current cycle count |

## Verification
The bench uses the defaults: three slots, a 16-bit cycle count and a divide ceiling of 39. With three slots, every ordered triple of the eleven class codes 0 to 10, including two illegal codes, can be swept from a clear unit state with a 1-cycle divide. That sweep covers all port collisions and every ALU fallback to port 1. The 6-bit latency input can exceed the ceiling, so the clamp is tested at both ends. Directed sequences then cover the float-multiply gap, divider spacing at latencies 5 and 39, branch spacing, and younger uops issuing past blocked ones.

// File: rtl/disp_pkg.sv
package disp_pkg;

    typedef enum logic [3:0] {
        CLS_ALU  = 4'd0,
        CLS_IMUL = 4'd1,
        CLS_FMUL = 4'd2,
        CLS_DIV  = 4'd3,
        CLS_FADD = 4'd4,
        CLS_LOAD = 4'd5,
        CLS_STA  = 4'd6,
        CLS_STD  = 4'd7,
        CLS_BR   = 4'd8
    } op_cls_e;

    localparam int NUM_PORTS = 5;
    localparam int PORT_W    = 3;
    localparam int CLS_W     = 4;

    localparam int LAT_SHORT = 1;
    localparam int LAT_FADD  = 3;
    localparam int LAT_IMUL  = 4;
    localparam int LAT_FMUL  = 5;

    // Fixed latency per class; the divider latency is supplied at run time.
    function automatic int unsigned lat_of(input logic [CLS_W-1:0] cls, input int unsigned div_lat);
        int unsigned lat;
        case (cls)
            CLS_FADD: lat = LAT_FADD;
            CLS_IMUL: lat = LAT_IMUL;
            CLS_FMUL: lat = LAT_FMUL;
            CLS_DIV:  lat = div_lat;
            default:  lat = LAT_SHORT;
        endcase
        return lat;
    endfunction

endpackage

// File: rtl/disp_unit_gate.sv
module disp_unit_gate #(
    parameter int DIV_MAX = 39,
    parameter int DIV_W   = $clog2(DIV_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_lat_i,
    input  logic             fmul_issued_i,
    input  logic             div_issued_i,
    input  logic             br_issued_i,
    output logic             mul_ok_o,
    output logic             div_ok_o,
    output logic             br_ok_o,
    output logic [DIV_W-1:0] div_lat_eff_o
);

    typedef struct packed {
        logic             mul_gap;
        logic             br_last;
        logic [DIV_W-1:0] div_left;
    } gate_st_t;

    gate_st_t st_d, st_q;
    logic [DIV_W-1:0] lat_eff;

    always_comb begin
        if (div_lat_i == '0) begin
            lat_eff = DIV_W'(1);
        end else if (div_lat_i > DIV_W'(DIV_MAX)) begin
            lat_eff = DIV_W'(DIV_MAX);
        end else begin
            lat_eff = div_lat_i;
        end

        st_d         = st_q;
        st_d.mul_gap = fmul_issued_i;
        st_d.br_last = br_issued_i;
        if (div_issued_i) begin
            st_d.div_left = lat_eff - DIV_W'(1);
        end else if (st_q.div_left != '0) begin
            st_d.div_left = st_q.div_left - DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mul_ok_o      = !st_q.mul_gap;
    assign br_ok_o       = !st_q.br_last;
    assign div_ok_o      = (st_q.div_left == '0);
    assign div_lat_eff_o = lat_eff;

endmodule

// File: rtl/disp_port_arb.sv
module disp_port_arb
    import disp_pkg::*;
#(
    parameter int NSLOT = 3
) (
    input  logic [NSLOT-1:0]             valid_i,
    input  logic [NSLOT-1:0][CLS_W-1:0]  cls_i,
    input  logic                         mul_ok_i,
    input  logic                         div_ok_i,
    input  logic                         br_ok_i,
    output logic [NSLOT-1:0]             grant_o,
    output logic [NSLOT-1:0][PORT_W-1:0] port_o,
    output logic                         fmul_issued_o,
    output logic                         div_issued_o,
    output logic                         br_issued_o
);

    logic [NUM_PORTS-1:0] taken;
    logic                 hit;
    logic [PORT_W-1:0]    sel;

    always_comb begin
        taken         = '0;
        grant_o       = '0;
        port_o        = '0;
        fmul_issued_o = 1'b0;
        div_issued_o  = 1'b0;
        br_issued_o   = 1'b0;
        hit           = 1'b0;
        sel           = '0;
        for (int i = 0; i < NSLOT; i++) begin
            hit = 1'b0;
            sel = '0;
            if (valid_i[i]) begin
                case (cls_i[i])
                    CLS_ALU: begin
                        if (!taken[0]) begin
                            hit = 1'b1; sel = PORT_W'(0);
                        end else if (!taken[1]) begin
                            hit = 1'b1; sel = PORT_W'(1);
                        end
                    end
                    CLS_IMUL, CLS_FMUL: begin
                        if (mul_ok_i && !taken[0]) begin
                            hit = 1'b1; sel = PORT_W'(0);
                        end
                    end
                    CLS_DIV: begin
                        if (div_ok_i && !taken[0]) begin
                            hit = 1'b1; sel = PORT_W'(0);
                        end
                    end
                    CLS_FADD: begin
                        if (!taken[0]) begin
                            hit = 1'b1; sel = PORT_W'(0);
                        end
                    end
                    CLS_LOAD: begin
                        if (!taken[2]) begin
                            hit = 1'b1; sel = PORT_W'(2);
                        end
                    end
                    CLS_STA: begin
                        if (!taken[3]) begin
                            hit = 1'b1; sel = PORT_W'(3);
                        end
                    end
                    CLS_STD: begin
                        if (!taken[4]) begin
                            hit = 1'b1; sel = PORT_W'(4);
                        end
                    end
                    CLS_BR: begin
                        if (br_ok_i && !taken[1]) begin
                            hit = 1'b1; sel = PORT_W'(1);
                        end
                    end
                    default: hit = 1'b0;
                endcase
            end
            if (hit) begin
                grant_o[i] = 1'b1;
                port_o[i]  = sel;
                taken[sel] = 1'b1;
                if (cls_i[i] == CLS_FMUL) fmul_issued_o = 1'b1;
                if (cls_i[i] == CLS_DIV)  div_issued_o  = 1'b1;
                if (cls_i[i] == CLS_BR)   br_issued_o   = 1'b1;
            end
        end
    end

endmodule

// File: rtl/disp_issue_ctrl.sv
module disp_issue_ctrl
    import disp_pkg::*;
#(
    parameter int NSLOT   = 3,
    parameter int CYC_W   = 16,
    parameter int DIV_MAX = 39,
    parameter int DIV_W   = $clog2(DIV_MAX + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NSLOT-1:0]          uop_valid_i,
    input  logic [CLS_W*NSLOT-1:0]    uop_cls_i,
    input  logic [DIV_W-1:0]          div_lat_i,
    output logic [NSLOT-1:0]          grant_o,
    output logic [PORT_W*NSLOT-1:0]   port_o,
    output logic [CYC_W*NSLOT-1:0]    done_o,
    output logic [CYC_W-1:0]          cycle_o
);

    typedef struct packed {
        logic [CYC_W-1:0] cyc;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NSLOT-1:0][CLS_W-1:0]  cls_w;
    logic [NSLOT-1:0][PORT_W-1:0] port_w;
    logic [NSLOT-1:0]             grant_w;
    logic                         mul_ok, div_ok, br_ok;
    logic                         fmul_iss, div_iss, br_iss;
    logic [DIV_W-1:0]             div_lat_eff;

    assign cls_w = uop_cls_i;

    disp_unit_gate #(
        .DIV_MAX (DIV_MAX),
        .DIV_W   (DIV_W)
    ) u_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .div_lat_i     (div_lat_i),
        .fmul_issued_i (fmul_iss),
        .div_issued_i  (div_iss),
        .br_issued_i   (br_iss),
        .mul_ok_o      (mul_ok),
        .div_ok_o      (div_ok),
        .br_ok_o       (br_ok),
        .div_lat_eff_o (div_lat_eff)
    );

    disp_port_arb #(
        .NSLOT (NSLOT)
    ) u_arb (
        .valid_i       (uop_valid_i),
        .cls_i         (cls_w),
        .mul_ok_i      (mul_ok),
        .div_ok_i      (div_ok),
        .br_ok_i       (br_ok),
        .grant_o       (grant_w),
        .port_o        (port_w),
        .fmul_issued_o (fmul_iss),
        .div_issued_o  (div_iss),
        .br_issued_o   (br_iss)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cyc = st_q.cyc + CYC_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        for (genvar g = 0; g < NSLOT; g++) begin : g_stamp
            logic [CYC_W-1:0] lat_s;
            assign lat_s = CYC_W'(lat_of(cls_w[g], int'(div_lat_eff)));
            assign done_o[g*CYC_W +: CYC_W] = grant_w[g] ? (st_q.cyc + lat_s) : '0;
        end
    endgenerate

    assign grant_o = grant_w;
    assign port_o  = port_w;
    assign cycle_o = st_q.cyc;

endmodule

// File: rtl/disp_issue_chk.sv
module disp_issue_chk
    import disp_pkg::*;
#(
    parameter int NSLOT   = 3,
    parameter int DIV_MAX = 39,
    parameter int DIV_W   = $clog2(DIV_MAX + 1)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NSLOT-1:0]        uop_valid_i,
    input logic [CLS_W*NSLOT-1:0]  uop_cls_i,
    input logic [DIV_W-1:0]        div_lat_i,
    input logic [NSLOT-1:0]        grant_o,
    input logic [PORT_W*NSLOT-1:0] port_o
);

    logic fmul_g, mul_g, div_g, br_g, map_bad, clash;
    logic [NUM_PORTS-1:0][3:0] use_cnt;
    logic [DIV_W-1:0] wait_cnt, lat_c;

    always_comb begin
        fmul_g  = 1'b0; mul_g = 1'b0; div_g = 1'b0; br_g = 1'b0;
        map_bad = 1'b0; clash = 1'b0;
        use_cnt = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (grant_o[i]) begin
                case (uop_cls_i[i*CLS_W +: CLS_W])
                    CLS_FMUL: begin fmul_g = 1'b1; mul_g = 1'b1; end
                    CLS_IMUL: mul_g = 1'b1;
                    CLS_DIV:  div_g = 1'b1;
                    CLS_BR:   br_g  = 1'b1;
                    default: ;
                endcase
                case (uop_cls_i[i*CLS_W +: CLS_W])
                    CLS_LOAD: map_bad = map_bad | (port_o[i*PORT_W +: PORT_W] != 3'd2);
                    CLS_STA:  map_bad = map_bad | (port_o[i*PORT_W +: PORT_W] != 3'd3);
                    CLS_STD:  map_bad = map_bad | (port_o[i*PORT_W +: PORT_W] != 3'd4);
                    CLS_BR:   map_bad = map_bad | (port_o[i*PORT_W +: PORT_W] != 3'd1);
                    CLS_ALU:  map_bad = map_bad | (port_o[i*PORT_W +: PORT_W] > 3'd1);
                    default:  map_bad = map_bad | (port_o[i*PORT_W +: PORT_W] != 3'd0);
                endcase
                for (int p = 0; p < NUM_PORTS; p++) begin
                    if (port_o[i*PORT_W +: PORT_W] == PORT_W'(p)) use_cnt[p] = use_cnt[p] + 4'd1;
                end
            end
        end
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (use_cnt[p] > 4'd1) clash = 1'b1;
        end
        if (div_lat_i == '0) lat_c = DIV_W'(1);
        else if (div_lat_i > DIV_W'(DIV_MAX)) lat_c = DIV_W'(DIV_MAX);
        else lat_c = div_lat_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_cnt <= '0;
        end else if (div_g) begin
            wait_cnt <= lat_c - DIV_W'(1);
        end else if (wait_cnt != '0) begin
            wait_cnt <= wait_cnt - DIV_W'(1);
        end
    end

    assert_grant_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~uop_valid_i) == '0);

    assert_port_map_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !map_bad);

    assert_port_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !clash);

    assert_fmul_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fmul_g |=> !mul_g);

    assert_div_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        div_g |-> (wait_cnt == '0));

    assert_branch_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        br_g |=> !br_g);

endmodule

bind disp_issue_ctrl disp_issue_chk #(
    .NSLOT   (NSLOT),
    .DIV_MAX (DIV_MAX),
    .DIV_W   (DIV_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .uop_valid_i (uop_valid_i),
    .uop_cls_i   (uop_cls_i),
    .div_lat_i   (div_lat_i),
    .grant_o     (grant_o),
    .port_o      (port_o)
);

// File: tb/test_disp_issue_ctrl.sv
module test_disp_issue_ctrl;

    localparam int NSLOT = 3;
    localparam int CYC_W = 16;
    localparam int DIV_W = 6;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [NSLOT-1:0]       uop_valid_i = '0;
    logic [4*NSLOT-1:0]     uop_cls_i = '0;
    logic [DIV_W-1:0]       div_lat_i = 6'd1;
    logic [NSLOT-1:0]       grant_o;
    logic [3*NSLOT-1:0]     port_o;
    logic [CYC_W*NSLOT-1:0] done_o;
    logic [CYC_W-1:0]       cycle_o;

    int checks = 0;
    int errors = 0;
    int bcyc   = 0;
    int exp_g[3];
    int exp_p[3];

    always #2 clk = ~clk;

    disp_issue_ctrl i_disp_issue_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .uop_valid_i (uop_valid_i),
        .uop_cls_i   (uop_cls_i),
        .div_lat_i   (div_lat_i),
        .grant_o     (grant_o),
        .port_o      (port_o),
        .done_o      (done_o),
        .cycle_o     (cycle_o)
    );

    always @(posedge clk) begin
        if (!rst_n) bcyc <= 0;
        else        bcyc <= bcyc + 1;
    end

    task automatic chk(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at cycle %0d", req, act, exp, bcyc);
        end
    endtask

    // c < 0 means the slot is not offered
    task automatic drive(input int c0, input int c1, input int c2);
        int cs[3];
        cs[0] = c0; cs[1] = c1; cs[2] = c2;
        for (int j = 0; j < 3; j++) begin
            uop_valid_i[j]     = (cs[j] >= 0);
            uop_cls_i[j*4 +: 4] = (cs[j] >= 0) ? 4'(cs[j]) : 4'd0;
        end
        #1;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int gr(input int j);
        return int'(grant_o[j]);
    endfunction

    function automatic int pt(input int j);
        return int'(port_o[j*3 +: 3]);
    endfunction

    function automatic int dn(input int j);
        return int'(done_o[j*CYC_W +: CYC_W]);
    endfunction

    function automatic int lat(input int c, input int dl);
        case (c)
            1: return 4;
            2: return 5;
            3: return dl;
            4: return 3;
            default: return 1;
        endcase
    endfunction

    // expected grants and ports from a clear unit state (R1 R2 R3 R4)
    task automatic model(input int c0, input int c1, input int c2);
        int cs[3];
        bit tk[5];
        cs[0] = c0; cs[1] = c1; cs[2] = c2;
        for (int p = 0; p < 5; p++) tk[p] = 0;
        for (int j = 0; j < 3; j++) begin
            int want;
            want = -1;
            case (cs[j])
                0: if (!tk[0]) want = 0; else if (!tk[1]) want = 1;
                1, 2, 3, 4: if (!tk[0]) want = 0;
                5: if (!tk[2]) want = 2;
                6: if (!tk[3]) want = 3;
                7: if (!tk[4]) want = 4;
                8: if (!tk[1]) want = 1;
                default: want = -1;
            endcase
            exp_g[j] = (want >= 0) ? 1 : 0;
            exp_p[j] = (want >= 0) ? want : 0;
            if (want >= 0) tk[want] = 1;
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int t0;
        int k;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        drive(-1, -1, -1);

        // R9: reset state
        chk(int'(cycle_o), 0, "R9 cycle count after reset");
        chk(int'(grant_o), 0, "R1 no grant with nothing offered");

        // R9: first cycle after reset: multiply, branch and divide all open
        div_lat_i = 6'd1;
        drive(2, 8, 5);
        chk(gr(0), 1, "R9 fmul open after reset");
        chk(gr(1), 1, "R9 branch open after reset");
        chk(dn(0), (bcyc + 5) % 65536, "R5 fmul stamp");
        tick();
        drive(-1, -1, -1);
        tick();

        // R1 R2 R3 R4 R5: sweep of all class triples from a clear state
        for (int a = 0; a < 11; a++) begin
            for (int b = 0; b < 11; b++) begin
                for (int c = 0; c < 11; c++) begin
                    drive(a, b, c);
                    model(a, b, c);
                    chk(int'(cycle_o), bcyc % 65536, "R5 cycle count");
                    for (int j = 0; j < 3; j++) begin
                        chk(gr(j), exp_g[j], "R1 R3 R4 sweep grant");
                        if (exp_g[j] == 1) begin
                            chk(pt(j), exp_p[j], "R2 R4 sweep port");
                            chk(dn(j), (bcyc + lat(j == 0 ? a : (j == 1 ? b : c), 1)) % 65536,
                                "R5 sweep stamp");
                        end
                    end
                    tick();
                    drive(-1, -1, -1);
                    tick();
                end
            end
        end

        // R6: float multiply gap, integer multiply does not gap
        drive(2, -1, -1);
        chk(gr(0), 1, "R6 fmul granted");
        tick();
        drive(1, 0, -1);
        chk(gr(0), 0, "R6 imul blocked after fmul");
        // R10: blocked imul claims no port; younger ALU takes port 0
        chk(gr(1), 1, "R10 ALU passes blocked imul");
        chk(pt(1), 0, "R10 ALU on port 0");
        tick();
        drive(1, -1, -1);
        chk(gr(0), 1, "R6 imul granted two cycles after fmul");
        chk(dn(0), (bcyc + 4) % 65536, "R5 imul stamp");
        tick();
        drive(1, -1, -1);
        chk(gr(0), 1, "R6 imul back to back");
        tick();
        drive(2, -1, -1);
        chk(gr(0), 1, "R6 fmul after imul");
        tick();
        drive(2, -1, -1);
        chk(gr(0), 0, "R6 fmul blocked after fmul");
        tick();
        drive(-1, -1, -1);
        tick();

        // R7: divide with latency 5
        div_lat_i = 6'd5;
        drive(3, -1, -1);
        chk(gr(0), 1, "R7 div granted");
        chk(dn(0), (bcyc + 5) % 65536, "R5 div stamp latency 5");
        t0 = bcyc;
        tick();
        k = 1;
        while (k < 5) begin
            drive(3, 4, -1);
            chk(gr(0), 0, "R7 div blocked while busy");
            chk(gr(1), 1, "R10 fadd passes busy divide");
            tick();
            k++;
        end
        drive(3, -1, -1);
        chk(bcyc - t0, 5, "R7 spacing cycles");
        chk(gr(0), 1, "R7 div granted after latency");
        tick();
        drive(-1, -1, -1);
        repeat (6) tick();

        // R7: clamp to 1 for zero
        div_lat_i = 6'd0;
        drive(3, -1, -1);
        chk(gr(0), 1, "R7 div lat 0 first");
        chk(dn(0), (bcyc + 1) % 65536, "R7 lat 0 counts as 1");
        tick();
        drive(3, -1, -1);
        chk(gr(0), 1, "R7 div lat 0 back to back");
        tick();

        // R7: clamp to 39 above the ceiling
        div_lat_i = 6'd50;
        drive(3, -1, -1);
        chk(gr(0), 1, "R7 div lat 50 granted");
        chk(dn(0), (bcyc + 39) % 65536, "R7 lat 50 clamps to 39");
        tick();
        for (int m = 1; m < 39; m++) begin
            drive(3, -1, -1);
            chk(gr(0), 0, "R7 long div blocked");
            tick();
        end
        drive(3, -1, -1);
        chk(gr(0), 1, "R7 div granted at 39");
        tick();
        drive(-1, -1, -1);
        tick();

        // R8: branch spacing and same-cycle branches
        drive(8, 8, -1);
        chk(gr(0), 1, "R8 first branch");
        chk(gr(1), 0, "R3 second branch same cycle");
        tick();
        drive(8, 0, -1);
        chk(gr(0), 0, "R8 branch blocked next cycle");
        chk(gr(1), 1, "R10 ALU passes blocked branch");
        chk(pt(1), 0, "R4 ALU on port 0");
        tick();
        drive(8, -1, -1);
        chk(gr(0), 1, "R8 branch after gap");
        chk(dn(0), (bcyc + 1) % 65536, "R5 branch stamp");
        tick();

        // R1: offered bit clear with a legal class
        drive(-1, -1, -1);
        uop_cls_i = 12'h555;
        #1;
        chk(int'(grant_o), 0, "R1 invalid slots not granted");
        tick();

        finish_run();
    end

endmodule